// File: doc/BRIEF.md
# Conversion Start and Sleep Sequencer

This block is the digital control core of a sampling converter, clocked by a system clock. It watches an asynchronous, edge-sensitive conversion-start request. It then drives a busy flag and a hold strobe for the track/hold. It also issues a one-cycle load strobe at the moment a conversion result, offered on a parallel input, is copied into the output register. Every analog duration is a cycle count set by a parameter.

The block has two operating behaviours, and no mode register chooses between them. The level of the request line at the end of a conversion picks the next behaviour. If the line is high, the block stays awake and the next falling edge starts a conversion of fixed length. If the line is low, the block goes to sleep. A rising edge then fires a wake-up one-shot. When the falling edge arrives during wake-up, the hold begins at once but the conversion waits for the wake-up to end. When the falling edge arrives after wake-up, the conversion runs its normal length from that edge.

Two other rules apply. A falling edge counts only after the line has been high long enough. A falling edge that lands late in the wake-up window raises a one-cycle warning.

The states are ST_AWAKE, ST_CONVERT, ST_ASLEEP, ST_WAKE and ST_WAKE_HELD. The transitions are:
- ST_AWAKE to ST_CONVERT on a qualified fall.
- ST_CONVERT to ST_AWAKE (line high) or to ST_ASLEEP (line low) when the conversion timer ends.
- ST_ASLEEP to ST_WAKE on a rise.
- ST_WAKE to ST_WAKE_HELD on a qualified fall before the wake timer ends.
- ST_WAKE to ST_CONVERT, ST_AWAKE or ST_ASLEEP when the wake timer ends. A fall at that same edge gives ST_CONVERT. Otherwise the line level decides: high gives ST_AWAKE, low gives ST_ASLEEP.
- ST_WAKE_HELD to ST_CONVERT when the wake timer ends.

Top module: `convstart_seq`

## Requirements
- R1: While reset is held, busy, hold, asleep, load_stb and early_warn are 0 and data_out is all zeros.
- R2: In the awake state, a qualified falling edge of conv_req that is sampled at clock edge E drives busy and hold high from edge E+2. Both stay high for exactly CONV_CYC cycles.
- R3: At the edge where busy falls after a conversion, the following happen together:
  - data_out takes the value on result_in at that edge.
  - load_stb is high for exactly one cycle.
  - hold drops with busy.
  - Changes on result_in at any other time do not reach data_out.
- R4: A falling edge of conv_req while busy is high is ignored and does not move the end of the conversion.
- R5: If conv_req is high when a conversion ends, asleep stays 0. If it is low, asleep is 1 from that edge.
- R6: While asleep, a rising edge sampled at edge E starts a wake-up of WAKE_CYC cycles from edge E+2, and asleep drops at E+2. If conv_req stays high through the wake-up, busy stays low. A later qualified fall then converts for CONV_CYC cycles, as in R2.
- R7: For a qualified fall that lands during the wake-up, busy and hold rise two edges after the fall is sampled. The conversion ends WAKE_CYC+CONV_CYC cycles after the wake-up began.
- R8: A falling edge counts only if the synchronised conv_req was high for at least MIN_PULSE cycles just before it. An unqualified fall during wake-up starts nothing, and the block returns to sleep when the wake-up ends.
- R9: early_warn pulses for one cycle, together with the rise of busy, when a qualified fall lands in the wake-up at least EARLY_CYC cycles after the wake-up began and before it ends. It stays low for earlier falls and for falls after the wake-up.
- R10: A rising edge of conv_req outside the sleep state has no effect on busy, hold or asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_req | input | 1 | Asynchronous conversion-start request; edges matter, level at end of conversion picks the next mode |
| result_in | input | RES_W | Conversion result from the converter datapath |
| busy | output | 1 | High while a conversion is pending or running |
| hold | output | 1 | High while the track/hold should hold |
| asleep | output | 1 | High while powered down |
| load_stb | output | 1 | One-cycle strobe when data_out is loaded |
| data_out | output | RES_W | Output register with the last result |
| early_warn | output | 1 | One-cycle warning for a start fall late in the wake-up window |

## Verification
Every conv_req edge passes two synchroniser stages. As a result, busy, hold and asleep change exactly two clock edges after the edge that first samples the change. load_stb, data_out and the busy fall then follow a further CONV_CYC edges, or WAKE_CYC+CONV_CYC edges counted from the start of wake-up. The bench drives conv_req just after a falling clock edge and counts rising edges from that point. It samples one cycle before and one cycle after each due edge, so an output that is early or late by a single cycle is caught. Pulse-count monitors confirm that load_stb and early_warn each fire exactly once or not at all over a whole scenario.

// File: rtl/cs_pkg.sv
package cs_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE     = 3'd0,
        ST_CONVERT   = 3'd1,
        ST_ASLEEP    = 3'd2,
        ST_WAKE      = 3'd3,
        ST_WAKE_HELD = 3'd4
    } seq_state_t;

endpackage

// File: rtl/cs_start_sync.sv
// Two-flop synchroniser for the start request, edge detection and a
// high-run qualifier that rejects falls after too short a high level.
module cs_start_sync #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic rise,
    output logic fall_ok
);
    localparam int HW = $clog2(MIN_PULSE + 1);
    localparam logic [HW-1:0] HI_LIM = HW'(MIN_PULSE);

    logic          meta_q;
    logic          sync_q;
    logic          prev_q;
    logic [HW-1:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b1;
            sync_q   <= 1'b1;
            prev_q   <= 1'b1;
            hi_run_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (!sync_q)
                hi_run_q <= '0;
            else if (hi_run_q < HI_LIM)
                hi_run_q <= hi_run_q + 1'b1;
        end
    end

    assign level   = sync_q;
    assign rise    = sync_q & ~prev_q;
    assign fall_ok = ~sync_q & prev_q & (hi_run_q >= HI_LIM);

endmodule

// File: rtl/cs_timer.sv
// Loadable down-counter shared by wake-up and conversion intervals.
module cs_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt     = cnt_q;
    assign expired = (cnt_q == '0);

    // R6/R2: an interval only ever shrinks by one per cycle unless reloaded
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cs_result_reg.sv
// Output register holding the most recent conversion result.
module cs_result_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end

    // R3: result only changes on a load
    p_keep_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));

endmodule

// File: rtl/convstart_seq.sv
module convstart_seq
    import cs_pkg::*;
#(
    parameter int RES_W     = 14,
    parameter int WAKE_CYC  = 500,
    parameter int CONV_CYC  = 500,
    parameter int MIN_PULSE = 4,
    parameter int EARLY_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_req,
    input  logic [RES_W-1:0] result_in,
    output logic             busy,
    output logic             hold,
    output logic             asleep,
    output logic             load_stb,
    output logic [RES_W-1:0] data_out,
    output logic             early_warn
);
    localparam int LONGEST = (WAKE_CYC > CONV_CYC) ? WAKE_CYC : CONV_CYC;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] WAKE_LD  = TW'(WAKE_CYC - 1);
    localparam logic [TW-1:0] CONV_LD  = TW'(CONV_CYC - 1);
    localparam logic [TW-1:0] WARN_LIM = TW'(WAKE_CYC - EARLY_CYC);

    logic            start_lvl;
    logic            start_rise;
    logic            start_fall_ok;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic [TW-1:0]   tmr_cnt;
    logic            tmr_done;
    logic            eoc;
    logic            warn_d;
    seq_state_t      state_q;
    seq_state_t      state_d;

    cs_start_sync #(.MIN_PULSE(MIN_PULSE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (conv_req),
        .level   (start_lvl),
        .rise    (start_rise),
        .fall_ok (start_fall_ok)
    );

    cs_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .expired  (tmr_done)
    );

    cs_result_reg #(.W(RES_W)) u_result (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (eoc),
        .din   (result_in),
        .dout  (data_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_AWAKE;
        else
            state_q <= state_d;
    end

    // Next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = CONV_LD;
        eoc      = 1'b0;
        warn_d   = 1'b0;
        unique case (state_q)
            ST_AWAKE: begin
                if (start_fall_ok) begin
                    state_d  = ST_CONVERT;
                    tmr_load = 1'b1;
                end
            end
            ST_CONVERT: begin
                if (tmr_done) begin
                    eoc     = 1'b1;
                    state_d = start_lvl ? ST_AWAKE : ST_ASLEEP;
                end
            end
            ST_ASLEEP: begin
                if (start_rise) begin
                    state_d  = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = WAKE_LD;
                end
            end
            ST_WAKE: begin
                if (tmr_done) begin
                    if (start_fall_ok) begin
                        state_d  = ST_CONVERT;
                        tmr_load = 1'b1;
                    end else if (start_lvl) begin
                        state_d = ST_AWAKE;
                    end else begin
                        state_d = ST_ASLEEP;
                    end
                end else if (start_fall_ok) begin
                    state_d = ST_WAKE_HELD;
                    warn_d  = (tmr_cnt <= WARN_LIM);
                end
            end
            ST_WAKE_HELD: begin
                if (tmr_done) begin
                    state_d  = ST_CONVERT;
                    tmr_load = 1'b1;
                end
            end
            default: state_d = ST_AWAKE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_stb   <= 1'b0;
            early_warn <= 1'b0;
        end else begin
            load_stb   <= eoc;
            early_warn <= warn_d;
        end
    end

    assign busy   = (state_q == ST_CONVERT) || (state_q == ST_WAKE_HELD);
    assign hold   = busy;
    assign asleep = (state_q == ST_ASLEEP);

    // R2: a qualified fall while awake leads to busy on the next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AWAKE && start_fall_ok) |=> busy);

    // R3: the busy fall coincides with the load strobe
    p_fall_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> load_stb);

    // R3: load strobe lasts one cycle
    p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    // R4: a running conversion is not cut short or restarted
    p_conv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && !tmr_done) |=> (state_q == ST_CONVERT));

    // R5: sleep is only entered with the request line low
    p_sleep_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> !start_lvl);

    // R9: warning is a single-cycle pulse coincident with busy
    p_warn_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        early_warn |=> !early_warn);
    p_warn_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        early_warn |-> busy);

endmodule

// File: tb/convstart_seq_bench.sv
module convstart_seq_bench;
    localparam int RW    = 14;
    localparam int WAKE  = 50;
    localparam int CONV  = 40;
    localparam int MINP  = 4;
    localparam int EARLY = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_req = 1'b1;
    logic [RW-1:0] result_in = '0;
    logic          busy;
    logic          hold;
    logic          asleep;
    logic          load_stb;
    logic [RW-1:0] data_out;
    logic          early_warn;

    int n_chk = 0;
    int n_bad = 0;
    int load_seen = 0;
    int warn_seen = 0;
    int busy_seen = 0;

    always #5 clk = ~clk;

    convstart_seq #(
        .RES_W(RW), .WAKE_CYC(WAKE), .CONV_CYC(CONV),
        .MIN_PULSE(MINP), .EARLY_CYC(EARLY)
    ) u_convstart_seq (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .result_in(result_in),
        .busy(busy), .hold(hold), .asleep(asleep), .load_stb(load_stb),
        .data_out(data_out), .early_warn(early_warn)
    );

    always @(negedge clk) begin
        if (load_stb)   load_seen++;
        if (early_warn) warn_seen++;
        if (busy)       busy_seen++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // advance past n rising edges, then sample after the falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        step(3);
        check("R1 busy", busy, 0);
        check("R1 hold", hold, 0);
        check("R1 asleep", asleep, 0);
        check("R1 load_stb", load_stb, 0);
        check("R1 data_out", data_out, 0);
        check("R1 early_warn", early_warn, 0);
        rst_n = 1'b1;
        step(10);
    endtask

    // awake conversion with extra edges during busy
    task automatic t_fast();
        result_in = 14'h0123;
        conv_req  = 1'b0;
        step(2);
        check("R2 busy early", busy, 0);
        step(1);
        check("R2 busy", busy, 1);
        check("R2 hold", hold, 1);
        load_seen = 0;
        conv_req = 1'b1;                  // R10 rise while converting
        step(7);
        conv_req = 1'b0;                  // R4 qualified fall while busy
        step(5);
        conv_req = 1'b1;
        result_in = 14'h1A5C;
        step(CONV - 13);
        check("R4 busy before end", busy, 1);
        check("R3 no early load", load_stb, 0);
        check("R10 asleep during conv", asleep, 0);
        step(1);
        check("R4 busy end", busy, 0);
        check("R3 hold end", hold, 0);
        check("R3 load_stb", load_stb, 1);
        check("R3 data_out", data_out, 32'h1A5C);
        check("R5 stay awake", asleep, 0);
        step(1);
        check("R3 load one cycle", load_stb, 0);
        check("R3 load count", load_seen, 1);
        result_in = 14'h2222;
        step(10);
        check("R3 data kept", data_out, 32'h1A5C);
        check("R10 idle", busy, 0);
    endtask

    task automatic t_to_sleep(input logic [RW-1:0] val);
        result_in = val;
        conv_req  = 1'b0;
        step(2 + CONV);
        check("R2 busy last", busy, 1);
        step(1);
        check("R2 busy end", busy, 0);
        check("R3 load", load_stb, 1);
        check("R3 data", data_out, 32'(val));
        check("R5 asleep", asleep, 1);
        step(5);
    endtask

    // fall during wake-up, k cycles after the rise
    task automatic t_short(input int k, input logic exp_warn, input logic [RW-1:0] val);
        conv_req = 1'b1;
        step(3);
        check("R6 wake asleep", asleep, 0);
        check("R6 wake busy", busy, 0);
        step(k - 3);
        conv_req  = 1'b0;
        warn_seen = 0;
        result_in = val;
        step(2);
        check("R7 busy early", busy, 0);
        step(1);
        check("R7 busy", busy, 1);
        check("R7 hold", hold, 1);
        check("R9 warn", early_warn, exp_warn);
        step(1);
        check("R9 warn width", early_warn, 0);
        step(3 + WAKE + CONV - 1 - (k + 4));
        check("R7 busy last", busy, 1);
        check("R7 no early load", load_stb, 0);
        step(1);
        check("R7 busy end", busy, 0);
        check("R7 load", load_stb, 1);
        check("R7 data", data_out, 32'(val));
        check("R5 asleep again", asleep, 1);
        check("R9 warn count", warn_seen, 32'(exp_warn));
        step(5);
    endtask

    // start pulse longer than the wake-up
    task automatic t_long(input logic [RW-1:0] val);
        conv_req  = 1'b1;
        warn_seen = 0;
        step(3);
        check("R6 awake", asleep, 0);
        step(WAKE - 1);
        check("R6 no busy in wake", busy, 0);
        step(15);
        check("R6 awake after wake", asleep, 0);
        check("R6 idle after wake", busy, 0);
        conv_req  = 1'b0;
        result_in = val;
        step(2);
        check("R6 busy early", busy, 0);
        step(1);
        check("R6 busy", busy, 1);
        step(CONV - 1);
        check("R6 busy last", busy, 1);
        step(1);
        check("R6 busy end", busy, 0);
        check("R6 load", load_stb, 1);
        check("R6 data", data_out, 32'(val));
        check("R9 no warn after wake", warn_seen, 0);
        step(5);
    endtask

    // start pulse too short to qualify its fall
    task automatic t_glitch();
        busy_seen = 0;
        load_seen = 0;
        conv_req  = 1'b1;
        step(2);
        conv_req = 1'b0;
        step(WAKE + 10);
        check("R8 no busy", busy_seen, 0);
        check("R8 no load", load_seen, 0);
        check("R8 back asleep", asleep, 1);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fast();
        t_to_sleep(14'h2AAA);
        t_short(30, 1'b1, 14'h0F0F);
        t_short(10, 1'b0, 14'h3FFF);
        t_long(14'h0001);
        t_glitch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule